// File: doc/BRIEF.md
# Clock source select and divide unit

This block is the clock control logic of a small microcontroller. Three oscillators feed it: a low-frequency crystal, a high-frequency crystal and an internal tuned oscillator. The oscillators are modelled as single-cycle tick inputs that are already synchronised into the master clock domain. From these ticks the block derives three clock-enable pulse streams: an auxiliary enable, a main enable and a subsystem enable. Each stream has its own source choice and a divide-by-1/2/4/8 ratio. Dividers are counters in the master clock domain that emit single-cycle enable pulses, so no clock is gated anywhere.

Two 8-bit control registers and a fault-clear location sit behind a small synchronous register port. A sticky oscillator-fault flag forces the main enable onto the internal oscillator. The block drives on/off controls for both crystals. A crystal is turned off only when software asks for it and no main or subsystem route is using that crystal.

Top module: `clkgen_ctrl`

## Requirements
- R1: After a synchronous reset: control register 1 = 0x80, control register 2 = 0x00, fault flag = 0, main_src = 0 (internal), high-frequency crystal off, low-frequency crystal on, lf_fast_mode = 0.
- R2: The register port uses address 0 for control register 1 and address 1 for control register 2. Both read back exactly what was written. Address 2 reads the fault flag in bit 0 and zero in bits 7:1. Address 3 reads zero, and writes to it change nothing.
- R3: aux_pulse is always fed by the low-frequency ticks. It is divided by 1, 2, 4 or 8 according to control register 1 bits 5:4 = 0, 1, 2, 3.
- R4: The main source is set by control register 2 bits 7:6. Codes 0 and 1 select the internal oscillator, 2 the high-frequency crystal and 3 the low-frequency crystal. It is reported on main_src as 0 = internal, 1 = high-frequency, 2 = low-frequency.
- R5: main_pulse divides the ticks of the main source by 1, 2, 4 or 8, set by control register 2 bits 5:4.
- R6: control register 2 bit 3 selects the subsystem source: 0 = internal, 1 = high-frequency crystal. The source is reported on sub_src with the R4 encoding. Bits 2:1 set its 1/2/4/8 ratio.
- R7: The fault flag is set on the cycle after fault_in is seen high and then holds. Writing address 2 with bit 0 = 1 clears it, and the clear wins over fault_in in that cycle. If fault_in is still high, the flag is set again one cycle later.
- R8: While the fault flag is 1, main_src is 0 (internal), whatever control register 2 bits 7:6 hold.
- R9: hf_osc_on is 0 only when control register 1 bit 7 is 1 and neither main_src nor sub_src is the high-frequency crystal.
- R10: lf_osc_on is 0 only when control register 1 bit 3 is 1 and neither main_src nor sub_src is the low-frequency crystal.
- R11: lf_fast_mode equals control register 1 bit 6.
- R12: A pulse appears the cycle after the source tick that completes the count. A ratio written mid-count applies only after the next terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| fault_in | input | 1 | Oscillator fault indication |
| lf_tick | input | 1 | Low-frequency crystal tick |
| hf_tick | input | 1 | High-frequency crystal tick |
| int_tick | input | 1 | Internal oscillator tick |
| aux_pulse | output | 1 | Auxiliary clock enable pulse |
| main_pulse | output | 1 | Main clock enable pulse |
| sub_pulse | output | 1 | Subsystem clock enable pulse |
| main_src | output | 2 | Effective main source |
| sub_src | output | 2 | Effective subsystem source |
| hf_osc_on | output | 1 | High-frequency crystal enable |
| lf_osc_on | output | 1 | Low-frequency crystal enable |
| lf_fast_mode | output | 1 | Low-frequency input speed mode |
| fault_flag | output | 1 | Sticky oscillator fault flag |

## Verification
Two events can land in one cycle: a software clear of the fault flag and a fault_in that is still high. The bench drives exactly that case with the main route on the high-frequency crystal and that crystal's off bit set. The expected result is the flag low for one cycle, so main_src briefly returns to the selected crystal, and then the flag high again. The crystal enable has to follow each step. Random stimulus also sends ticks while register writes change ratios and sources mid-count. A bench reference model judges every pulse cycle by cycle.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int REG_W     = 8;
    localparam int DIV_SEL_W = 2;
    localparam int NUM_OUT   = 3;

    localparam logic [REG_W-1:0] CTL1_RST = 8'h80;
    localparam logic [REG_W-1:0] CTL2_RST = 8'h00;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_HF  = 2'd1,
        SRC_LF  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ADDR_CTL1  = 2'd0,
        ADDR_CTL2  = 2'd1,
        ADDR_FAULT = 2'd2
    } addr_e;

    typedef struct packed {
        src_e                 src;
        logic [DIV_SEL_W-1:0] div;
    } route_t;

    localparam int ROUTE_AUX  = 0;
    localparam int ROUTE_MAIN = 1;
    localparam int ROUTE_SUB  = 2;

    function automatic src_e decode_main(input logic [1:0] code, input logic fault);
        src_e s;
        if (fault) begin
            s = SRC_INT;
        end else begin
            case (code)
                2'd2:    s = SRC_HF;
                2'd3:    s = SRC_LF;
                default: s = SRC_INT;
            endcase
        end
        return s;
    endfunction

    function automatic src_e decode_sub(input logic sel);
        return sel ? SRC_HF : SRC_INT;
    endfunction

    function automatic logic pick_tick(input src_e s, input logic t_int,
                                       input logic t_hf, input logic t_lf);
        logic t;
        case (s)
            SRC_HF:  t = t_hf;
            SRC_LF:  t = t_lf;
            default: t = t_int;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             fault_in,
    output logic [REG_W-1:0] ctl1_o,
    output logic [REG_W-1:0] ctl2_o,
    output logic [REG_W-1:0] rd_data_o,
    output logic             fault_o
);

    logic [REG_W-1:0] ctl1_q, ctl2_q;
    logic             fault_q;
    logic             clear_req;

    assign clear_req = wr_en && (wr_addr == ADDR_FAULT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1_q  <= CTL1_RST;
            ctl2_q  <= CTL2_RST;
            fault_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTL1) ctl1_q <= wr_data;
            if (wr_en && wr_addr == ADDR_CTL2) ctl2_q <= wr_data;
            // clear has priority; a persisting fault re-arms on the next edge
            fault_q <= clear_req ? 1'b0 : (fault_q | fault_in);
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTL1:  rd_data_o = ctl1_q;
            ADDR_CTL2:  rd_data_o = ctl2_q;
            ADDR_FAULT: rd_data_o = {{(REG_W-1){1'b0}}, fault_q};
            default:    rd_data_o = '0;
        endcase
    end

    assign ctl1_o  = ctl1_q;
    assign ctl2_o  = ctl2_q;
    assign fault_o = fault_q;

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(fault_in) && !$past(clear_req)) |-> fault_q);

    assert_fault_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(clear_req)) |-> !fault_q);

endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             pulse_o
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] lim_q;
    logic             at_end;
    logic             pulse_q;

    assign at_end = (cnt_q == ((CNT_W'(1) << lim_q) - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            lim_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick_i && at_end;
            if (tick_i) begin
                if (at_end) begin
                    cnt_q <= '0;
                    lim_q <= div_sel_i;   // new ratio only at terminal count
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign pulse_o = pulse_q;

    assert_pulse_needs_tick_R12: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(tick_i));

endmodule

// File: rtl/clkgen_oscctl.sv
module clkgen_oscctl
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hf_off_req,
    input  logic lf_off_req,
    input  src_e main_src_i,
    input  src_e sub_src_i,
    output logic hf_on_o,
    output logic lf_on_o
);

    logic hf_used, lf_used;

    assign hf_used = (main_src_i == SRC_HF) || (sub_src_i == SRC_HF);
    assign lf_used = (main_src_i == SRC_LF) || (sub_src_i == SRC_LF);

    assign hf_on_o = !(hf_off_req && !hf_used);
    assign lf_on_o = !(lf_off_req && !lf_used);

    assert_hf_kept_in_use_R9: assert property (@(posedge clk) disable iff (rst)
        ((main_src_i == SRC_HF) || (sub_src_i == SRC_HF)) |-> hf_on_o);

    assert_lf_kept_in_use_R10: assert property (@(posedge clk) disable iff (rst)
        ((main_src_i == SRC_LF) || (sub_src_i == SRC_LF)) |-> lf_on_o);

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             fault_in,
    input  logic             lf_tick,
    input  logic             hf_tick,
    input  logic             int_tick,
    output logic             aux_pulse,
    output logic             main_pulse,
    output logic             sub_pulse,
    output logic [1:0]       main_src,
    output logic [1:0]       sub_src,
    output logic             hf_osc_on,
    output logic             lf_osc_on,
    output logic             lf_fast_mode,
    output logic             fault_flag
);

    logic [REG_W-1:0] ctl1, ctl2;
    logic             fault;
    route_t           routes [NUM_OUT];
    logic [NUM_OUT-1:0] pulses;

    clkgen_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .fault_in  (fault_in),
        .ctl1_o    (ctl1),
        .ctl2_o    (ctl2),
        .rd_data_o (rd_data),
        .fault_o   (fault)
    );

    always_comb begin
        routes[ROUTE_AUX]  = '{src: SRC_LF,                          div: ctl1[5:4]};
        routes[ROUTE_MAIN] = '{src: decode_main(ctl2[7:6], fault),   div: ctl2[5:4]};
        routes[ROUTE_SUB]  = '{src: decode_sub(ctl2[3]),             div: ctl2[2:1]};
    end

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
            logic tick_sel;
            assign tick_sel = pick_tick(routes[g].src, int_tick, hf_tick, lf_tick);
            clkgen_divider #(.SEL_W(DIV_SEL_W)) u_div (
                .clk       (clk),
                .rst       (rst),
                .tick_i    (tick_sel),
                .div_sel_i (routes[g].div),
                .pulse_o   (pulses[g])
            );
        end
    endgenerate

    clkgen_oscctl u_osc (
        .clk        (clk),
        .rst        (rst),
        .hf_off_req (ctl1[7]),
        .lf_off_req (ctl1[3]),
        .main_src_i (routes[ROUTE_MAIN].src),
        .sub_src_i  (routes[ROUTE_SUB].src),
        .hf_on_o    (hf_osc_on),
        .lf_on_o    (lf_osc_on)
    );

    assign aux_pulse    = pulses[ROUTE_AUX];
    assign main_pulse   = pulses[ROUTE_MAIN];
    assign sub_pulse    = pulses[ROUTE_SUB];
    assign main_src     = routes[ROUTE_MAIN].src;
    assign sub_src      = routes[ROUTE_SUB].src;
    assign lf_fast_mode = ctl1[6];
    assign fault_flag   = fault;

    assert_fault_forces_int_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (main_src == SRC_INT));

    assert_aux_only_lf_R3: assert property (@(posedge clk) disable iff (rst)
        aux_pulse |-> $past(lf_tick));

endmodule

// File: tb/test_clkgen_ctrl.sv
module test_clkgen_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic       fault_in = 1'b0;
    logic       lf_tick = 1'b0, hf_tick = 1'b0, int_tick = 1'b0;
    logic [7:0] rd_data;
    logic       aux_pulse, main_pulse, sub_pulse;
    logic [1:0] main_src, sub_src;
    logic       hf_osc_on, lf_osc_on, lf_fast_mode, fault_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit auto_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkgen_ctrl i_clkgen_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fault_in(fault_in),
        .lf_tick(lf_tick), .hf_tick(hf_tick), .int_tick(int_tick),
        .aux_pulse(aux_pulse), .main_pulse(main_pulse), .sub_pulse(sub_pulse),
        .main_src(main_src), .sub_src(sub_src), .hf_osc_on(hf_osc_on),
        .lf_osc_on(lf_osc_on), .lf_fast_mode(lf_fast_mode), .fault_flag(fault_flag)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_r1, m_r2;
    bit         m_flag;
    int         m_cnt [3];
    int         m_lim [3];
    bit         m_en  [3];

    function automatic int exp_main(input logic [7:0] r2, input bit flag);
        if (flag) return 0;
        if (r2[7:6] == 2'd2) return 1;
        if (r2[7:6] == 2'd3) return 2;
        return 0;
    endfunction

    function automatic int exp_sub(input logic [7:0] r2);
        return r2[3] ? 1 : 0;
    endfunction

    function automatic bit tick_of(input int src);
        if (src == 1) return hf_tick;
        if (src == 2) return lf_tick;
        return int_tick;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_r1;
            2'd1: return m_r2;
            2'd2: return {7'd0, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_r1 = 8'h80; m_r2 = 8'h00; m_flag = 0;
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_lim[i] = 0; m_en[i] = 0; end
        end else begin
            int src [3];
            int dsel [3];
            src[0] = 2;                    dsel[0] = m_r1[5:4];
            src[1] = exp_main(m_r2, m_flag); dsel[1] = m_r2[5:4];
            src[2] = exp_sub(m_r2);        dsel[2] = m_r2[2:1];
            for (int i = 0; i < 3; i++) begin
                m_en[i] = 0;
                if (tick_of(src[i])) begin
                    if (m_cnt[i] == (1 << m_lim[i]) - 1) begin
                        m_en[i] = 1; m_cnt[i] = 0; m_lim[i] = dsel[i];
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end
            end
            if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_flag = 0;
            else m_flag = m_flag | fault_in;
            if (wr_en && wr_addr == 2'd0) m_r1 = wr_data;
            if (wr_en && wr_addr == 2'd1) m_r2 = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (auto_on && !rst) begin
            int em, es;
            em = exp_main(m_r2, m_flag);
            es = exp_sub(m_r2);
            chk(aux_pulse == m_en[0], "R3 aux pulse", aux_pulse, m_en[0]);
            chk(main_pulse == m_en[1], "R5 main pulse", main_pulse, m_en[1]);
            chk(sub_pulse == m_en[2], "R6 sub pulse", sub_pulse, m_en[2]);
            chk(main_src == em, "R4 main source", main_src, em);
            chk(sub_src == es, "R6 sub source", sub_src, es);
            chk(fault_flag == m_flag, "R7 fault flag", fault_flag, m_flag);
            chk(hf_osc_on == !(m_r1[7] && em != 1 && es != 1), "R9 hf enable", hf_osc_on,
                !(m_r1[7] && em != 1 && es != 1));
            chk(lf_osc_on == !(m_r1[3] && em != 2 && es != 2), "R10 lf enable", lf_osc_on,
                !(m_r1[3] && em != 2 && es != 2));
            chk(lf_fast_mode == m_r1[6], "R11 speed mode", lf_fast_mode, m_r1[6]);
            chk(rd_data == exp_rd(rd_addr), "R2 readback", rd_data, exp_rd(rd_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_addr = 2'd0; #1;
        chk(rd_data == 8'h80, "R1 ctl1 reset", rd_data, 8'h80);
        rd_addr = 2'd1; #1;
        chk(rd_data == 8'h00, "R1 ctl2 reset", rd_data, 8'h00);
        chk(main_src == 2'd0, "R1 main on internal", main_src, 0);
        chk(hf_osc_on == 1'b0, "R1 hf off", hf_osc_on, 0);
        chk(lf_osc_on == 1'b1, "R1 lf on", lf_osc_on, 1);
        chk(fault_flag == 1'b0, "R1 fault clear", fault_flag, 0);
        chk(lf_fast_mode == 1'b0, "R1 slow mode", lf_fast_mode, 0);
        auto_on = 1'b1;

        // R2 address 3 ignored
        wr(2'd3, 8'hFF);
        @(negedge clk);
        rd_addr = 2'd3; #1;
        chk(rd_data == 8'h00, "R2 addr3 reads zero", rd_data, 0);
        rd_addr = 2'd0; #1;
        chk(rd_data == 8'h80, "R2 addr3 write ignored", rd_data, 8'h80);

        // R9: hf off request refused while main uses hf
        wr(2'd1, 8'h80);
        @(negedge clk);
        chk(main_src == 2'd1, "R4 main on hf", main_src, 1);
        chk(hf_osc_on == 1'b1, "R9 hf kept while used", hf_osc_on, 1);

        // R8 fault forces internal, hf then released
        @(posedge clk); #2 fault_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(fault_flag == 1'b1, "R7 flag set", fault_flag, 1);
        chk(main_src == 2'd0, "R8 forced internal", main_src, 0);
        chk(hf_osc_on == 1'b0, "R9 hf released under fault", hf_osc_on, 0);

        // R7 clear while fault_in held: one low cycle, then set again
        wr(2'd2, 8'h01);
        @(negedge clk);
        chk(fault_flag == 1'b0, "R7 cleared", fault_flag, 0);
        chk(main_src == 2'd1, "R8 select restored", main_src, 1);
        chk(hf_osc_on == 1'b1, "R9 hf back on", hf_osc_on, 1);
        @(negedge clk);
        chk(fault_flag == 1'b1, "R7 re-set by held fault", fault_flag, 1);
        #2 fault_in = 1'b0;
        wr(2'd2, 8'h01);

        // R12 divide by 4 on aux, ratio change mid-count
        wr(2'd0, 8'h28);   // aux /4, lf off request
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #2 lf_tick = 1'b1;
            if (k == 5) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h08; end
            @(posedge clk); #2 lf_tick = 1'b0; wr_en = 1'b0;
        end
        chk(lf_osc_on == 1'b0, "R10 lf off when unused", lf_osc_on, 0);
        wr(2'd1, 8'hC0);
        @(negedge clk);
        chk(lf_osc_on == 1'b1, "R10 lf kept while main uses it", lf_osc_on, 1);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            @(posedge clk); #2;
            lf_tick  = $urandom_range(0, 1);
            hf_tick  = $urandom_range(0, 1);
            int_tick = $urandom_range(0, 1);
            rd_addr  = 2'($urandom_range(0, 3));
            fault_in = ($urandom_range(0, 40) == 0) ? 1'b1 : (fault_in && $urandom_range(0, 2) != 0);
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1'b1; wr_addr = 2'($urandom_range(0, 3)); wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(posedge clk); #2 wr_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule